// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates five interrupt sources for an 8-bit processor core. Each source has a request flag, an enable bit, a priority bit and a vector address of its own, and a global enable gates the whole set. The flags are either edge-captured or level-following, chosen per source. The controller picks one winner among the pending and enabled flags and raises `irq_o` together with the winner's vector. The core answers with an acknowledge pulse.

The controller keeps a two-bit record of the priority levels whose handlers are in progress. A high-level request can interrupt a low-level handler. A low-level request never interrupts any handler. A return-from-interrupt pulse closes the innermost level. After every return, no new request is raised until the core reports one further completed instruction.

Top module: `irq_prio_ctrl`

## Requirements
- R1: There are five sources, indexed 0 to 4. The vector presented for winner n is 0x0003 + 8*n, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: When `src_edge_i[n]`=1, flag n is set on the clock after a 0-to-1 change of `src_req_i[n]` and is held until it is acknowledged. When `src_edge_i[n]`=0, flag n copies `src_req_i[n]` one clock later, and an acknowledge does not clear it.
- R3: A source with `src_en_i[n]`=0 still records its flag on `flag_o`, but it is never chosen and raises no request.
- R4: While `glob_en_i`=0, `irq_o` stays 0 whatever flags are pending.
- R5: `src_prio_i[n]`=1 makes source n high level. Any pending high-level source wins over every pending low-level source, whatever the indices.
- R6: Among pending sources of the same level, the lowest index wins.
- R7: An acknowledge taken while `irq_o`=1 sets the winner's level bit in `active_o` (bit 1 for high, bit 0 for low) on the next clock, and clears the winner's flag if that source is edge-type. After reset, `active_o`=0 and every flag is 0.
- R8: A high-level winner is raised while `active_o[1]`=0. A low-level winner is raised only while `active_o`=0.
- R9: A `reti_i` pulse clears `active_o[1]` if it is set, and otherwise clears `active_o[0]`. When a return and an acknowledge fall in the same cycle, the clear is applied first and the winner's bit is then set.
- R10: After a `reti_i` pulse, `irq_o` stays 0 until `insn_done_i` has been seen in a later cycle. An `insn_done_i` in the same cycle as the return does not count.
- R11: An acknowledge taken while `irq_o`=0 changes neither `active_o` nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 5 | Raw request lines, one per source |
| src_edge_i | input | 5 | Per-source flag type: 1 edge, 0 level |
| src_en_i | input | 5 | Per-source enable |
| src_prio_i | input | 5 | Per-source level: 1 high, 0 low |
| glob_en_i | input | 1 | Global interrupt enable |
| insn_done_i | input | 1 | Pulse at each completed instruction |
| ack_i | input | 1 | Core accepts the presented request |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 16 | Vector address of the current winner |
| active_o | output | 2 | Levels in service: bit 1 high, bit 0 low |
| flag_o | output | 5 | Current request flags |

## Verification
A return and an acknowledge can land in the same cycle, because `irq_o` is still high while the core retires a handler. The bench provokes this by leaving a low handler active with a high source pending, then pulsing `reti_i` and `ack_i` together. The result is judged correct when `active_o` reads 2'b10 on the next clock and `irq_o` is held low by the post-return hold-off. A second overlap, where `insn_done_i` arrives in the same cycle as the return, is checked by confirming that the request stays suppressed until a later completed instruction.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
  typedef logic [1:0] act_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= req_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise;
    assign rise = req_i[i] & ~prev_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (edge_i[i]) flag_q[i] <= rise | (flag_q[i] & ~clr_i[i]);
      else                flag_q[i] <= req_i[i];
    end

    // R2 / R7: an acknowledged edge flag drops unless a new edge arrives
    assert_edge_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[i] && clr_i[i] && !rise) |=> !flag_q[i]);
    // R2: a level flag follows its input
    assert_level_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_i[i] |=> (flag_q[i] == $past(req_i[i])));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  prio_i,
  input  act_t             act_i,
  output logic             grant_o,
  output logic             win_hi_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [NSRC-1:0]  win_oh_o
);
  logic [NSRC-1:0]  cand_hi, cand_lo;
  logic [IDX_W-1:0] idx_hi, idx_lo;

  assign cand_hi = pend_i & prio_i;
  assign cand_lo = pend_i & ~prio_i;

  // Scan downward so the lowest index is written last and wins
  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) idx_hi = IDX_W'(i);
      if (cand_lo[i]) idx_lo = IDX_W'(i);
    end
  end

  always_comb begin
    grant_o   = 1'b0;
    win_hi_o  = 1'b0;
    win_idx_o = idx_lo;
    if (|cand_hi && !act_i[LVL_HI]) begin
      grant_o   = 1'b1;
      win_hi_o  = 1'b1;
      win_idx_o = idx_hi;
    end else if (|cand_lo && act_i == '0) begin
      grant_o   = 1'b1;
    end
  end

  always_comb begin
    win_oh_o = '0;
    if (grant_o) win_oh_o[win_idx_o] = 1'b1;
  end

  // R8: with any handler active only a high-level winner may be granted
  assert_no_low_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && act_i != '0) |-> prio_i[win_idx_o]);
  // R5: a granted low winner means no high source is pending
  assert_hi_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !win_hi_o) |-> ((pend_i & prio_i) == '0));
  // R6: the winner is pending and one-hot
  assert_win_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh_o) && ((win_oh_o & ~pend_i) == '0));
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_prio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  input  logic insn_done_i,
  output act_t act_o,
  output logic hold_o
);
  act_t act_q, act_nxt;
  logic hold_q;

  always_comb begin
    act_nxt = act_q;
    if (reti_i) begin
      if (act_q[LVL_HI]) act_nxt[LVL_HI] = 1'b0;
      else               act_nxt[LVL_LO] = 1'b0;
    end
    if (take_i) act_nxt[take_hi_i ? LVL_HI : LVL_LO] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      act_q <= act_nxt;
      if (reti_i)           hold_q <= 1'b1;
      else if (insn_done_i) hold_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign hold_o = hold_q;

  // R7: taking a winner marks its level
  assert_take_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> act_q[$past(take_hi_i) ? LVL_HI : LVL_LO]);
  // R9: return without take closes the high level first
  assert_reti_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_i && act_q[LVL_HI]) |=> (act_q == {1'b0, $past(act_q[LVL_LO])}));
  // R10: a return always arms the hold-off
  assert_reti_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> hold_q);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = 5,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned IDX_W   = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_req_i,
  input  logic [NSRC-1:0]  src_edge_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic [NSRC-1:0]  src_prio_i,
  input  logic             glob_en_i,
  input  logic             insn_done_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [1:0]       active_o,
  output logic [NSRC-1:0]  flag_o
);
  logic [NSRC-1:0]  flag, clr;
  logic             grant, win_hi, hold, take;
  logic [IDX_W-1:0] win_idx;
  logic [NSRC-1:0]  win_oh;
  act_t             act;

  irq_flags #(.NSRC(NSRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (src_req_i),
    .edge_i (src_edge_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  irq_arb #(.NSRC(NSRC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (flag & src_en_i),
    .prio_i    (src_prio_i),
    .act_i     (act),
    .grant_o   (grant),
    .win_hi_o  (win_hi),
    .win_idx_o (win_idx),
    .win_oh_o  (win_oh)
  );

  irq_level_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .take_hi_i   (win_hi),
    .reti_i      (reti_i),
    .insn_done_i (insn_done_i),
    .act_o       (act),
    .hold_o      (hold)
  );

  assign irq_o    = grant & glob_en_i & ~hold;
  assign take     = ack_i & irq_o;
  assign clr      = take ? win_oh : '0;
  assign vec_o    = VEC_W'(VEC_BASE + VEC_STEP * win_idx);
  assign active_o = act;
  assign flag_o   = flag;

  // R4: global enable gates the request
  assert_glob_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en_i |-> !irq_o);
  // R10: no request in the cycle after a return
  assert_reti_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !irq_o);
  // R11: a stray acknowledge leaves the levels alone
  assert_stray_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !reti_i) |=> $stable(active_o));
  // R1: the vector lies on the stride grid
  assert_vec_grid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o >= VEC_W'(VEC_BASE)) && (((vec_o - VEC_W'(VEC_BASE)) % VEC_STEP) == 0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req = '0, edg = '1, en = '1, prio = '0;
  logic        gen = 1'b1, insn = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic [1:0]  act;
  logic [4:0]  flg;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .src_edge_i(edg),
    .src_en_i(en), .src_prio_i(prio), .glob_en_i(gen), .insn_done_i(insn),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec),
    .active_o(act), .flag_o(flg)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int actual, int expect_v);
    n_run++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expect_v);
    end
  endtask

  task automatic pulse(logic [4:0] m);
    req = m; step(); req = '0;
  endtask

  task automatic do_ack();   ack = 1'b1;  step(); ack = 1'b0;  endtask
  task automatic do_reti();  reti = 1'b1; step(); reti = 1'b0; endtask
  task automatic do_insn();  insn = 1'b1; step(); insn = 1'b0; endtask

  task automatic defaults();
    req = '0; edg = '1; en = '1; prio = '0; gen = 1'b1;
  endtask

  task automatic t_reset();
    chk("R7 reset irq", irq, 0);
    chk("R7 reset active", act, 0);
    chk("R7 reset flags", flg, 0);
  endtask

  task automatic t_vectors();
    defaults();
    pulse(5'h1F);
    chk("R2 edge flags set", flg, 5'h1F);
    for (int n = 0; n < 5; n++) begin
      chk("R6 irq raised", irq, 1);
      chk("R1 R6 vector", vec, 3 + 8 * n);
      do_ack();
      chk("R7 low level marked", act, 1);
      chk("R7 edge flag cleared", flg[n], 0);
      do_reti();
      chk("R9 low cleared", act, 0);
      chk("R10 hold after reti", irq, 0);
      do_insn();
    end
  endtask

  task automatic t_glob();
    defaults();
    gen = 1'b0;
    pulse(5'h04);
    step();
    chk("R4 global mask", irq, 0);
    gen = 1'b1; #1;
    chk("R4 global on irq", irq, 1);
    chk("R4 global on vec", vec, 16'h0013);
    do_ack(); do_reti(); do_insn();
  endtask

  task automatic t_enable();
    defaults();
    en = 5'h1D;
    pulse(5'h02);
    chk("R3 disabled flag kept", flg[1], 1);
    chk("R3 disabled no irq", irq, 0);
    en = '1; #1;
    chk("R3 enabled vec", vec, 16'h000B);
    do_ack(); do_reti(); do_insn();
  endtask

  task automatic t_prio();
    defaults();
    prio = 5'h08;
    pulse(5'h09);
    chk("R5 high beats low", vec, 16'h001B);
    do_ack();
    chk("R7 high level marked", act, 2);
    chk("R8 low blocked by high", irq, 0);
    do_reti(); do_insn();
    chk("R8 low after return", vec, 16'h0003);
    do_ack();
    chk("R7 low marked", act, 1);
    prio = 5'h18;
    pulse(5'h10);
    chk("R8 high preempts low", irq, 1);
    chk("R8 preempt vector", vec, 16'h0023);
    do_ack();
    chk("R8 nested levels", act, 3);
    do_reti();
    chk("R9 high closed first", act, 1);
    do_insn(); do_reti(); do_insn();
    chk("R9 all closed", act, 0);
  endtask

  task automatic t_nolow();
    defaults();
    pulse(5'h01);
    do_ack();
    pulse(5'h02);
    chk("R8 low no preempt", irq, 0);
    do_reti(); do_insn();
    chk("R8 low served later", vec, 16'h000B);
    do_ack(); do_reti(); do_insn();
  endtask

  task automatic t_level();
    defaults();
    edg = 5'h1B;
    req = 5'h04; step();
    chk("R2 level flag follows", flg[2], 1);
    chk("R2 level vector", vec, 16'h0013);
    do_ack();
    chk("R2 level not cleared by ack", flg[2], 1);
    req = '0; step();
    chk("R2 level flag drops", flg[2], 0);
    do_reti(); do_insn();
  endtask

  task automatic t_same_cycle();
    defaults();
    pulse(5'h01);
    do_ack();
    prio = 5'h10;
    pulse(5'h10);
    chk("R9 high pending", irq, 1);
    ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
    chk("R9 reti and ack same cycle", act, 2);
    chk("R10 hold after combined", irq, 0);
    do_reti(); do_insn();
    chk("R9 combined closed", act, 0);
  endtask

  task automatic t_hold();
    defaults();
    pulse(5'h01);
    do_ack();
    pulse(5'h02);
    reti = 1'b1; insn = 1'b1; step(); reti = 1'b0; insn = 1'b0;
    chk("R10 same-cycle insn ignored", irq, 0);
    step();
    chk("R10 still held", irq, 0);
    do_insn();
    chk("R10 released", irq, 1);
    do_ack(); do_reti(); do_insn();
  endtask

  task automatic t_stray();
    defaults();
    gen = 1'b0;
    pulse(5'h08);
    do_ack();
    chk("R11 stray ack active", act, 0);
    chk("R11 stray ack flag", flg, 5'h08);
    gen = 1'b1; #1;
    do_ack(); do_reti(); do_insn();
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_vectors();
    t_glob();
    t_enable();
    t_prio();
    t_nolow();
    t_level();
    t_same_cycle();
    t_hold();
    t_stray();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule